// File: doc/BRIEF.md
# Fractional-Divider Serial Transceiver

A full-duplex asynchronous serial port with one transmit line and one receive line. Host-side characters travel through two small FIFOs. The rate is set by a source-clock prescaler and a fixed-point divider with three fractional bits. The fraction is accumulated from one bit period to the next, so rates that are not an integer number of source cycles per bit keep their average period without growing drift.

The character format is set by plain configuration inputs: 7 or 8 data bits, parity off or one of four kinds, and one or two stop bits. Configuration may only change while both directions are idle.

The transmit side accepts characters on a valid/ready stream. `tx_valid` with `tx_data` must be held until `tx_ready` is high at a rising clock edge; `tx_ready` is low only while the transmit FIFO is full. The receive side presents the oldest stored character on `rx_valid`/`rx_data`. The character is removed at a rising edge where both `rx_valid` and `rx_ready` are high. The receiver never stalls the line: when nothing can be stored, the character is dropped and flagged.

Top module: `frac_uart`

## Requirements
- R1: After reset, `txd` is high, both FIFO counts are 0, `tx_ready` is 1, `rx_valid` is 0, and all three error flags and `irq` are 0.
- R2: A transmitted frame is, in time order: one low start bit, the data bits LSB first (7 when `cfg_len8`=0, 8 when 1), the parity bit if `cfg_par_en`=1, then one high stop bit (two when `cfg_two_stop`=1). For example, 7-bit 0x45 with odd parity and two stop bits gives 0,1,0,1,0,0,0,1,0,1,1.
- R3: The parity bit is selected by `cfg_par_kind`: 0 = odd (data plus parity has an odd count of ones), 1 = even, 2 = always 1, 3 = always 0.
- R4: `cfg_clk_sel` values 0..3 select a source tick every 1, 2, 4 or 8 clocks. `cfg_div` is a 13.3 unsigned fixed-point count of source ticks per bit, with I = integer part and F = fraction. An n-bit transmitted frame lasts n·I + floor((n−1)·F/8) ticks. With `cfg_clk_sel`=0, back-to-back characters start n·I + floor((n−1)·F/8) + 1 clocks apart.
- R5: Each FIFO holds 4 characters. `tx_count` and `rx_count` report their fill, and `tx_ready` is 0 exactly while the transmit FIFO holds 4.
- R6: The receiver decodes frames in the configured format and stores each character in order. A 7-bit character is stored with bit 7 = 0.
- R7: A low pulse on `rxd` that has ended by the time half a bit period has passed is ignored and stores nothing.
- R8: A received parity bit that disagrees with R3 sets the sticky `parity_err`. The character is still stored.
- R9: A low level at the first stop-bit sample sets the sticky `frame_err`. The character is still stored.
- R10: A character completed while the receive FIFO is full is dropped and sets the sticky `overrun_err`. The stored characters are unchanged.
- R11: A one-cycle `err_clr` pulse clears all three error flags.
- R12: `irq` is the OR of the conditions enabled by `cfg_irq_en`: bit 0 = receive FIFO not empty, bit 1 = `parity_err`, bit 2 = `frame_err`, bit 3 = `overrun_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_clk_sel | input | 2 | Source-tick prescale select (/1, /2, /4, /8) |
| cfg_div | input | DIV_W | Source ticks per bit, 13.3 fixed point |
| cfg_len8 | input | 1 | 1 = 8 data bits, 0 = 7 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_kind | input | 2 | Parity kind (odd, even, one, zero) |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_irq_en | input | 4 | Interrupt condition enables |
| err_clr | input | 1 | Clears the sticky error flags |
| tx_valid | input | 1 | Transmit character offered |
| tx_ready | output | 1 | Transmit FIFO can accept |
| tx_data | input | 8 | Transmit character |
| rx_valid | output | 1 | Received character available |
| rx_ready | input | 1 | Host takes the received character |
| rx_data | output | 8 | Oldest received character |
| tx_count | output | $clog2(FIFO_DEPTH+1) | Transmit FIFO fill |
| rx_count | output | $clog2(FIFO_DEPTH+1) | Receive FIFO fill |
| parity_err | output | 1 | Sticky parity error |
| frame_err | output | 1 | Sticky framing error |
| overrun_err | output | 1 | Sticky receive overrun |
| irq | output | 1 | Combined interrupt request |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
The hardest situation to reach is a fractional divider whose extra source cycles fall at different bit positions in the transmitter and the receiver, because the receiver restarts its accumulator at a half period. Random loopback runs with random fractions and prescales put both timers through many carry patterns, and any drift that moved a mid-bit sample off its bit would corrupt the data. The error paths and the false-start case cannot be produced by the transmitter itself. For these, the bench drives `rxd` directly with deliberately wrong parity bits, low stop bits and short low glitches. It also holds `rx_ready` low across five characters to force an overrun.

// File: rtl/frac_uart_pkg.sv
package frac_uart_pkg;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ONE   = 2'd2,
    PAR_ZERO  = 2'd3
  } par_kind_e;

  localparam int FRAME_MAX = 12;

  function automatic logic calc_parity(input logic [7:0] d, input logic len8,
                                       input par_kind_e kind);
    logic ones;
    ones = (^d[6:0]) ^ (len8 & d[7]);
    case (kind)
      PAR_ODD:  return ~ones;
      PAR_EVEN: return ones;
      PAR_ONE:  return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      count <= '0;
    end else begin
      if (do_push) wr_q <= step(wr_q);
      if (do_pop)  rd_q <= step(rd_q);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  assert_fifo_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/uart_bit_timer.sv
module uart_bit_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             half,
  input  logic             run,
  input  logic             src_tick,
  input  logic [DIV_W-1:0] div,
  output logic             done
);
  localparam int IW = DIV_W - 3;

  logic [IW-1:0] cnt_q;
  logic [2:0]    acc_q;
  logic [IW-1:0] ipart;
  logic [3:0]    sum;

  assign ipart = div[DIV_W-1:3];
  assign sum   = {1'b0, acc_q} + {1'b0, div[2:0]};
  assign done  = run && src_tick && !restart && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (restart) begin
      acc_q <= '0;
      cnt_q <= (half ? (ipart >> 1) : ipart) - IW'(1);
    end else if (done) begin
      cnt_q <= ipart - IW'(1) + IW'(sum[3]);
      acc_q <= sum[2:0];
    end else if (run && src_tick) begin
      cnt_q <= cnt_q - IW'(1);
    end
  end

endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import frac_uart_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic [DIV_W-1:0] div,
  input  logic             len8,
  input  logic             par_en,
  input  par_kind_e        par_kind,
  input  logic             two_stop,
  input  logic             fifo_empty,
  input  logic [7:0]       fifo_data,
  output logic             pop,
  output logic             txd
);
  logic [FRAME_MAX-1:0] frame_q, frame_new;
  logic [3:0]           left_q, nbits;
  logic [3:0]           pidx;
  logic                 busy_q;
  logic                 bit_done;

  always_comb begin
    frame_new    = '1;
    frame_new[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < 7 || len8) frame_new[i+1] = fifo_data[i];
    end
    pidx = len8 ? 4'd9 : 4'd8;
    if (par_en) frame_new[pidx] = calc_parity(fifo_data, len8, par_kind);
    nbits = 4'd9 + 4'(len8) + 4'(par_en) + 4'(two_stop);
  end

  assign pop = !busy_q && !fifo_empty;
  assign txd = frame_q[0];

  uart_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(pop), .half(1'b0), .run(busy_q),
    .src_tick(src_tick), .div(div), .done(bit_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      left_q  <= '0;
      busy_q  <= 1'b0;
    end else if (pop) begin
      frame_q <= frame_new;
      left_q  <= nbits;
      busy_q  <= 1'b1;
    end else if (bit_done) begin
      if (left_q == 4'd1) begin
        busy_q  <= 1'b0;
        frame_q <= '1;
      end else begin
        frame_q <= {1'b1, frame_q[FRAME_MAX-1:1]};
      end
      left_q <= left_q - 4'd1;
    end
  end

  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !txd);
  assert_bits_left_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (left_q != 4'd0 && left_q <= 4'(FRAME_MAX)));

endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import frac_uart_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic [DIV_W-1:0] div,
  input  logic             len8,
  input  logic             par_en,
  input  par_kind_e        par_kind,
  input  logic             line,
  output logic             char_v,
  output logic [7:0]       char_data,
  output logic             char_perr,
  output logic             char_ferr
);
  typedef enum logic [1:0] {RX_IDLE, RX_CHECK, RX_BITS} rx_state_e;

  rx_state_e   state_q;
  logic        line_q;
  logic        fall;
  logic        bit_done;
  logic [3:0]  idx_q, need;
  logic [15:0] bits_q;
  logic [7:0]  data_w;
  logic        pbit_w;

  assign fall   = line_q && !line;
  assign need   = 4'd7 + 4'(len8) + 4'(par_en);
  assign data_w = len8 ? bits_q[7:0] : {1'b0, bits_q[6:0]};
  assign pbit_w = len8 ? bits_q[8] : bits_q[7];

  uart_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(state_q == RX_IDLE && fall), .half(1'b1),
    .run(state_q != RX_IDLE), .src_tick(src_tick), .div(div), .done(bit_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      line_q    <= 1'b1;
      idx_q     <= '0;
      bits_q    <= '0;
      char_v    <= 1'b0;
      char_data <= '0;
      char_perr <= 1'b0;
      char_ferr <= 1'b0;
    end else begin
      line_q <= line;
      char_v <= 1'b0;
      case (state_q)
        RX_IDLE:  if (fall) state_q <= RX_CHECK;
        RX_CHECK: if (bit_done) begin
          state_q <= line ? RX_IDLE : RX_BITS;
          idx_q   <= '0;
        end
        default: if (bit_done) begin
          if (idx_q == need) begin
            char_v    <= 1'b1;
            char_data <= data_w;
            char_perr <= par_en && (pbit_w != calc_parity(data_w, len8, par_kind));
            char_ferr <= !line;
            state_q   <= RX_IDLE;
          end else begin
            bits_q[idx_q] <= line;
            idx_q         <= idx_q + 4'd1;
          end
        end
      endcase
    end
  end

  assert_char_from_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    char_v |-> ($past(state_q) == RX_BITS && state_q == RX_IDLE));
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    char_v |=> !char_v);

endmodule

// File: rtl/frac_uart.sv
module frac_uart
  import frac_uart_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [1:0]                        cfg_clk_sel,
  input  logic [DIV_W-1:0]                  cfg_div,
  input  logic                              cfg_len8,
  input  logic                              cfg_par_en,
  input  logic [1:0]                        cfg_par_kind,
  input  logic                              cfg_two_stop,
  input  logic [3:0]                        cfg_irq_en,
  input  logic                              err_clr,
  input  logic                              tx_valid,
  output logic                              tx_ready,
  input  logic [7:0]                        tx_data,
  output logic                              rx_valid,
  input  logic                              rx_ready,
  output logic [7:0]                        rx_data,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]   tx_count,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]   rx_count,
  output logic                              parity_err,
  output logic                              frame_err,
  output logic                              overrun_err,
  output logic                              irq,
  output logic                              txd,
  input  logic                              rxd
);
  localparam int CW = $clog2(FIFO_DEPTH+1);

  logic [2:0] pre_q;
  logic [3:0] pre_mask;
  logic       src_tick;
  logic [1:0] rx_sync_q;
  logic       tx_full, tx_empty, tx_pop;
  logic [7:0] tx_head;
  logic       rx_full, rx_empty;
  logic       ch_v, ch_perr, ch_ferr;
  logic [7:0] ch_data;
  par_kind_e  kind;

  assign kind     = par_kind_e'(cfg_par_kind);
  assign pre_mask = (4'd1 << cfg_clk_sel) - 4'd1;
  assign src_tick = ((pre_q & pre_mask[2:0]) == pre_mask[2:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q       <= '0;
      rx_sync_q   <= 2'b11;
      parity_err  <= 1'b0;
      frame_err   <= 1'b0;
      overrun_err <= 1'b0;
    end else begin
      pre_q     <= pre_q + 3'd1;
      rx_sync_q <= {rx_sync_q[0], rxd};
      if (err_clr) begin
        parity_err  <= 1'b0;
        frame_err   <= 1'b0;
        overrun_err <= 1'b0;
      end
      if (ch_v && ch_perr)  parity_err  <= 1'b1;
      if (ch_v && ch_ferr)  frame_err   <= 1'b1;
      if (ch_v && rx_full)  overrun_err <= 1'b1;
    end
  end

  uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .push(tx_valid), .wdata(tx_data), .pop(tx_pop),
    .rdata(tx_head), .full(tx_full), .empty(tx_empty), .count(tx_count)
  );

  uart_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .div(cfg_div), .len8(cfg_len8),
    .par_en(cfg_par_en), .par_kind(kind), .two_stop(cfg_two_stop),
    .fifo_empty(tx_empty), .fifo_data(tx_head), .pop(tx_pop), .txd(txd)
  );

  uart_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .div(cfg_div), .len8(cfg_len8),
    .par_en(cfg_par_en), .par_kind(kind), .line(rx_sync_q[1]),
    .char_v(ch_v), .char_data(ch_data), .char_perr(ch_perr), .char_ferr(ch_ferr)
  );

  uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .push(ch_v), .wdata(ch_data), .pop(rx_ready),
    .rdata(rx_data), .full(rx_full), .empty(rx_empty), .count(rx_count)
  );

  assign tx_ready = !tx_full;
  assign rx_valid = !rx_empty;
  assign irq      = |(cfg_irq_en & {overrun_err, frame_err, parity_err, !rx_empty});

  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_err && !err_clr) |=> overrun_err);
  assert_ready_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready |-> (tx_count == CW'(FIFO_DEPTH)));
  assert_clear_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !ch_v) |=> (!parity_err && !frame_err && !overrun_err));

endmodule

// File: tb/frac_uart_tb.sv
module frac_uart_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_clk_sel = 0;
  logic [15:0] cfg_div = 16'd128;
  logic cfg_len8 = 1, cfg_par_en = 0, cfg_two_stop = 0;
  logic [1:0] cfg_par_kind = 0;
  logic [3:0] cfg_irq_en = 0;
  logic err_clr = 0, tx_valid = 0, rx_ready = 0;
  logic [7:0] tx_data = 0;
  logic tx_ready, rx_valid, parity_err, frame_err, overrun_err, irq, txd, rxd;
  logic [7:0] rx_data;
  logic [2:0] tx_count, rx_count;
  logic loop = 0, drv = 1;

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  assign rxd = loop ? txd : drv;

  frac_uart u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_clk_sel(cfg_clk_sel), .cfg_div(cfg_div),
    .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_kind(cfg_par_kind),
    .cfg_two_stop(cfg_two_stop), .cfg_irq_en(cfg_irq_en), .err_clr(err_clr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_count(tx_count), .rx_count(rx_count), .parity_err(parity_err),
    .frame_err(frame_err), .overrun_err(overrun_err), .irq(irq), .txd(txd), .rxd(rxd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic exp_par(input logic [7:0] d, input logic l8, input logic [1:0] k);
    logic x;
    x = l8 ? ^d : ^d[6:0];
    case (k)
      2'd0: return ~x;
      2'd1: return x;
      2'd2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int ndata();
    return cfg_len8 ? 8 : 7;
  endfunction

  function automatic int nbits();
    return 1 + ndata() + int'(cfg_par_en) + 1 + int'(cfg_two_stop);
  endfunction

  function automatic logic exp_bit(input logic [7:0] d, input int k);
    if (k == 0) return 1'b0;
    if (k <= ndata()) return d[k-1];
    if (cfg_par_en && k == ndata() + 1) return exp_par(d, cfg_len8, cfg_par_kind);
    return 1'b1;
  endfunction

  function automatic int bit_clks();
    return int'(cfg_div >> 3) << cfg_clk_sel;
  endfunction

  task automatic setcfg(input int sel, input int div, input bit l8, input bit pe,
                        input int kind, input bit ts);
    @(negedge clk);
    cfg_clk_sel = 2'(sel); cfg_div = 16'(div); cfg_len8 = l8; cfg_par_en = pe;
    cfg_par_kind = 2'(kind); cfg_two_stop = ts;
  endtask

  task automatic push_tx(input logic [7:0] d);
    tx_data = d; tx_valid = 1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic wait_start(output bit ok);
    int g = 0;
    ok = 1;
    while (txd) begin
      @(negedge clk); g++;
      if (g > 20000) begin ok = 0; return; end
    end
  endtask

  task automatic capture_tx(input logic [7:0] d, input string req);
    bit ok;
    int p = bit_clks();
    wait_start(ok);
    chk(ok, {req, " start seen"}, int'(ok), 1);
    repeat (p/2) @(negedge clk);
    for (int k = 0; k < nbits(); k++) begin
      chk(txd === exp_bit(d, k), req, int'(txd), int'(exp_bit(d, k)));
      if (k < nbits() - 1) repeat (p) @(negedge clk);
    end
    repeat (p) @(negedge clk);
  endtask

  task automatic drive_char(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    int p = bit_clks();
    for (int k = 0; k < nbits(); k++) begin
      logic b;
      b = exp_bit(d, k);
      if (bad_par && cfg_par_en && k == ndata() + 1) b = ~b;
      if (bad_stop && k == ndata() + 1 + int'(cfg_par_en)) b = 1'b0;
      drv = b;
      repeat (p) @(negedge clk);
    end
    drv = 1;
    repeat (p) @(negedge clk);
  endtask

  task automatic pop_rx(output logic [7:0] d);
    d = rx_data; rx_ready = 1;
    @(negedge clk);
    rx_ready = 0;
  endtask

  task automatic pulse_clr();
    err_clr = 1; @(negedge clk); err_clr = 0; @(negedge clk);
  endtask

  initial begin
    logic [7:0] got;
    logic [7:0] sent [5];
    int t0, t1, dur, expd;
    bit ok;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk(txd === 1'b1, "R1 txd idle", int'(txd), 1);
    chk(tx_count == 0 && rx_count == 0, "R1 counts", int'(tx_count) + int'(rx_count), 0);
    chk(tx_ready === 1'b1 && rx_valid === 1'b0, "R1 handshake", int'(tx_ready), 1);
    chk({parity_err, frame_err, overrun_err, irq} == 4'b0, "R1 flags",
        int'({parity_err, frame_err, overrun_err, irq}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2/R3: 7-bit 0x45, odd parity, two stop bits
    setcfg(0, 16 << 3, 0, 1, 0, 1);
    push_tx(8'h45);
    chk(exp_par(8'h45, 0, 0) == 1'b0, "R3 odd parity of 0x45", int'(exp_par(8'h45, 0, 0)), 0);
    capture_tx(8'h45, "R2 frame 0x45 7O2");

    // R3: every parity kind, 8-bit
    for (int kind = 0; kind < 4; kind++) begin
      logic [7:0] d;
      d = 8'($urandom);
      setcfg(0, 12 << 3, 1, 1, kind, 0);
      push_tx(d);
      capture_tx(d, $sformatf("R3 parity kind %0d", kind));
    end
    setcfg(0, 10 << 3, 1, 0, 0, 1);
    push_tx(8'h3C);
    capture_tx(8'h3C, "R2 no parity 8N2");

    // R4: fractional period, start-to-start spacing
    setcfg(0, (20 << 3) | 3, 1, 0, 0, 0);
    push_tx(8'hFF); push_tx(8'hFF);
    wait_start(ok); t0 = cyc;
    while (!txd) @(negedge clk);
    wait_start(ok); t1 = cyc;
    expd = 10*20 + (9*3)/8 + 1;
    chk(t1 - t0 == expd, "R4 fractional spacing", t1 - t0, expd);
    repeat (12*20) @(negedge clk);

    // R4: prescale /4, divider 8.0 -> 32 clocks per bit
    setcfg(2, 8 << 3, 1, 0, 0, 0);
    push_tx(8'hFF); push_tx(8'hFF);
    wait_start(ok); t0 = cyc;
    while (!txd) @(negedge clk);
    wait_start(ok); t1 = cyc;
    dur = t1 - t0;
    chk(dur >= 316 && dur <= 324, "R4 prescale /4 frame", dur, 320);
    repeat (12*32) @(negedge clk);

    // R5: transmit FIFO fills at 4
    setcfg(0, 8 << 3, 1, 0, 0, 0);
    for (int i = 0; i < 5; i++) push_tx(8'(i));
    chk(tx_count == 4, "R5 tx fill", int'(tx_count), 4);
    chk(tx_ready === 1'b0, "R5 tx_ready low when full", int'(tx_ready), 0);
    repeat (6*10*8) @(negedge clk);
    chk(tx_count == 0 && tx_ready, "R5 tx drained", int'(tx_count), 0);

    // R6/R12: directed receive
    setcfg(0, 16 << 3, 1, 1, 1, 0);
    cfg_irq_en = 4'b0001;
    drive_char(8'hA5, 0, 0);
    chk(rx_count == 1 && rx_valid, "R6 rx stored", int'(rx_count), 1);
    chk(rx_data == 8'hA5, "R6 rx data", int'(rx_data), 8'hA5);
    chk({parity_err, frame_err} == 2'b00, "R6 no errors", int'({parity_err, frame_err}), 0);
    chk(irq === 1'b1, "R12 irq on rx not empty", int'(irq), 1);
    pop_rx(got);
    chk(rx_count == 0 && irq === 1'b0, "R12 irq drops after pop", int'(irq), 0);
    setcfg(0, 16 << 3, 0, 0, 0, 0);
    drive_char(8'hC3, 0, 0);
    chk(rx_data == 8'h43, "R6 7-bit char bit7 zero", int'(rx_data), 8'h43);
    pop_rx(got);

    // R7: short glitch ignored
    drv = 0; repeat (bit_clks()/4) @(negedge clk); drv = 1;
    repeat (2*bit_clks()) @(negedge clk);
    chk(rx_count == 0 && !rx_valid, "R7 glitch ignored", int'(rx_count), 0);

    // R8: parity error
    setcfg(0, 16 << 3, 1, 1, 0, 0);
    cfg_irq_en = 4'b0010;
    drive_char(8'h5A, 1, 0);
    chk(parity_err === 1'b1, "R8 parity error", int'(parity_err), 1);
    chk(rx_count == 1 && rx_data == 8'h5A, "R8 char kept", int'(rx_data), 8'h5A);
    chk(irq === 1'b1, "R12 irq on parity error", int'(irq), 1);
    pulse_clr();
    chk(parity_err === 1'b0 && irq === 1'b0, "R11 clear parity", int'(parity_err), 0);
    pop_rx(got);

    // R9: framing error
    cfg_irq_en = 4'b0100;
    drive_char(8'h81, 0, 1);
    chk(frame_err === 1'b1, "R9 frame error", int'(frame_err), 1);
    chk(rx_count == 1 && rx_data == 8'h81, "R9 char kept", int'(rx_data), 8'h81);
    chk(irq === 1'b1, "R12 irq on frame error", int'(irq), 1);
    pulse_clr();
    chk(frame_err === 1'b0, "R11 clear frame", int'(frame_err), 0);
    pop_rx(got);

    // R10: overrun
    cfg_irq_en = 4'b1000;
    for (int i = 0; i < 5; i++) begin
      sent[i] = 8'($urandom);
      drive_char(sent[i], 0, 0);
    end
    chk(rx_count == 4, "R10 rx full", int'(rx_count), 4);
    chk(overrun_err === 1'b1 && irq === 1'b1, "R10 overrun flag", int'(overrun_err), 1);
    for (int i = 0; i < 4; i++) begin
      pop_rx(got);
      chk(got == sent[i], "R10 stored order kept", int'(got), int'(sent[i]));
    end
    chk(overrun_err === 1'b1, "R10 overrun sticky", int'(overrun_err), 1);
    pulse_clr();
    chk(overrun_err === 1'b0, "R11 clear overrun", int'(overrun_err), 0);

    // R4/R6: random loopback with fractional dividers
    loop = 1;
    cfg_irq_en = 4'b0;
    for (int it = 0; it < 24; it++) begin
      logic [7:0] d;
      int g;
      setcfg($urandom_range(0, 1), ($urandom_range(10, 30) << 3) | $urandom_range(0, 7),
             1'($urandom), 1'($urandom), $urandom_range(0, 3), 1'($urandom));
      d = 8'($urandom);
      push_tx(d);
      g = 0;
      while (!rx_valid && g < 20000) begin @(negedge clk); g++; end
      pop_rx(got);
      chk(got == (cfg_len8 ? d : {1'b0, d[6:0]}), "R6 loopback data", int'(got),
          int'(cfg_len8 ? d : {1'b0, d[6:0]}));
      chk({parity_err, frame_err, overrun_err} == 3'b0, "R4 loopback clean",
          int'({parity_err, frame_err, overrun_err}), 0);
      repeat (3*bit_clks() + 8) @(negedge clk);
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule